// File: doc/BRIEF.md
# Multi-Channel Critical Temperature Output

This block watches three temperature channels (remote 1, local, remote 2) and drives one active-low critical-temperature flag. Each channel has its own 8-bit critical limit and its own enable bit. A channel is judged only when its reading arrives with its valid strobe, once per monitoring cycle. The flag goes low when any enabled channel reads above its limit. It goes high again only when every channel that tripped has later reported a reading at or below its limit.

Readings are 10-bit codes. Bits [9:2] carry whole degrees and bits [1:0] carry quarter degrees. Limits are whole-degree 8-bit codes and are padded with two zero quarter bits. A format input selects how both readings and limits are read: offset-64 (the code minus 64) or two's complement. A limit at the bottom of its range turns off that channel's output function. The pad driver and the conversion logic sit outside this block.

Each channel runs a three-state machine that changes state only on its own strobe. `CH_OFF` means the channel is disarmed. `CH_CLEAR` means it is armed and the reading is at or below the limit. `CH_HOT` means it is armed and the reading is above the limit. The transitions are: arm (`CH_OFF`→`CH_CLEAR`), trip (`CH_CLEAR` or `CH_OFF`→`CH_HOT`), release (`CH_HOT`→`CH_CLEAR`) and disarm (any state→`CH_OFF`). On a strobe, disarm applies when the enable bit is 0 or the limit is at the bottom of its range. With no strobe, the state is held.

Top module: `crit_temp_out`

## Requirements
- R1: After reset every channel is in `CH_OFF` and `crit_n_o` is 1.
- R2: A strobe on an enabled channel whose reading is greater than its limit puts `crit_n_o` low in the cycle after that strobe's clock edge. The comparison is signed, so negative temperatures order correctly.
- R3: The reading must exceed the limit by at least one quarter degree to trip. A reading exactly equal to the limit does not trip. A reading of the limit plus 0.25 °C does trip.
- R4: A tripped channel stays tripped, and keeps `crit_n_o` low, on every cycle without a strobe, whatever its reading input does.
- R5: A tripped channel is released by a strobe whose reading is equal to or below its limit.
- R6: A channel whose enable bit (`en_i[k]`) is 0 when its strobe arrives goes to `CH_OFF` and never pulls `crit_n_o` low.
- R7: With `fmt_i`=0 (offset-64), a code c means c−64 °C. A limit code of 0 (−64 °C) disables the channel, while a limit code of 1 (−63 °C) still arms it.
- R8: With `fmt_i`=1 (two's complement), a limit code of 0x80 (−128 °C) disables the channel, while 0x81 (−127 °C) still arms it.
- R9: `crit_n_o` is low while any channel is tripped. It returns high only when no channel is tripped.
- R10: A strobe on one channel does not change the state of any other channel. Channel k uses bits [10k+9:10k] of `temp_i`, bits [8k+7:8k] of `lim_i`, and bit k of `en_i` and `vld_i`. Here k=0 is remote 1, k=1 is local and k=2 is remote 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 1 | 0: offset-64, 1: two's complement |
| en_i | input | 3 | Per-channel output enable |
| vld_i | input | 3 | Per-channel reading strobe |
| temp_i | input | 30 | Three 10-bit readings (quarter-degree) |
| lim_i | input | 24 | Three 8-bit whole-degree limits |
| crit_n_o | output | 1 | Active-low critical flag |

## Verification
Each channel's state register takes the strobe at one rising edge. The flag is a combinational OR of the channel states, so every result is visible in the same clock period as that edge and is due exactly one cycle after the strobe is presented. The bench changes inputs on the falling edge, holds the strobe for one period, and samples the flag on the next falling edge, after the capturing rising edge. Hold checks wait several strobe-free cycles, with the reading input changed, before sampling.

// File: rtl/crit_temp_pkg.sv
package crit_temp_pkg;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_CLEAR = 2'd1,
        CH_HOT   = 2'd2
    } ch_state_e;

    typedef enum logic {
        FMT_OFS64 = 1'b0,
        FMT_TWOS  = 1'b1
    } temp_fmt_e;

endpackage

// File: rtl/crit_temp_norm.sv
module crit_temp_norm #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 2,
    localparam int CODE_W = INT_W + FRAC_W,
    localparam int VAL_W  = CODE_W + 1
) (
    input  logic                    fmt_i,
    input  logic [CODE_W-1:0]       code_i,
    output logic signed [VAL_W-1:0] val_o
);
    import crit_temp_pkg::*;

    // offset-64 bias, scaled to the fractional resolution
    localparam int BIAS = 1 << (INT_W - 2 + FRAC_W);

    always_comb begin
        if (temp_fmt_e'(fmt_i) == FMT_TWOS)
            val_o = {code_i[CODE_W-1], code_i};
        else
            val_o = $signed({1'b0, code_i}) - VAL_W'(BIAS);
    end

endmodule

// File: rtl/crit_temp_chan.sv
module crit_temp_chan #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 2,
    localparam int TEMP_W = INT_W + FRAC_W,
    localparam int VAL_W  = TEMP_W + 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              fmt_i,
    input  logic              en_i,
    input  logic              vld_i,
    input  logic [TEMP_W-1:0] temp_i,
    input  logic [INT_W-1:0]  lim_i,
    output logic              hot_o
);
    import crit_temp_pkg::*;

    localparam logic signed [VAL_W-1:0] OFS_FLOOR  = -(VAL_W'(1) << (INT_W - 2 + FRAC_W));
    localparam logic signed [VAL_W-1:0] TWOS_FLOOR = -(VAL_W'(1) << (INT_W - 1 + FRAC_W));

    logic signed [VAL_W-1:0] temp_val;
    logic signed [VAL_W-1:0] lim_val;
    logic                    armed;
    logic                    over;
    ch_state_e               state_q, state_d;

    crit_temp_norm #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_norm_temp (
        .fmt_i  (fmt_i),
        .code_i (temp_i),
        .val_o  (temp_val)
    );

    crit_temp_norm #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_norm_lim (
        .fmt_i  (fmt_i),
        .code_i ({lim_i, {FRAC_W{1'b0}}}),
        .val_o  (lim_val)
    );

    always_comb begin
        if (temp_fmt_e'(fmt_i) == FMT_TWOS)
            armed = en_i && (lim_val > TWOS_FLOOR);
        else
            armed = en_i && (lim_val > OFS_FLOOR);
        over = temp_val > lim_val;
    end

    always_comb begin
        state_d = state_q;
        if (vld_i) begin
            unique case (state_q)
                CH_OFF, CH_CLEAR: begin
                    if (!armed)     state_d = CH_OFF;
                    else if (over)  state_d = CH_HOT;
                    else            state_d = CH_CLEAR;
                end
                CH_HOT: begin
                    if (!armed)     state_d = CH_OFF;
                    else if (!over) state_d = CH_CLEAR;
                    else            state_d = CH_HOT;
                end
                default:            state_d = CH_OFF;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= CH_OFF;
        else         state_q <= state_d;
    end

    always_comb begin
        hot_o = (state_q == CH_HOT);
    end

    // R4
    held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !vld_i |=> $stable(state_q));

    // R6
    off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (vld_i && !en_i) |=> !hot_o);

    // R2
    trip_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(hot_o) |-> $past(vld_i));

endmodule

// File: rtl/crit_temp_out.sv
module crit_temp_out #(
    parameter int NUM_CH = 3,
    parameter int INT_W  = 8,
    parameter int FRAC_W = 2,
    localparam int TEMP_W = INT_W + FRAC_W
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     fmt_i,
    input  logic [NUM_CH-1:0]        en_i,
    input  logic [NUM_CH-1:0]        vld_i,
    input  logic [NUM_CH*TEMP_W-1:0] temp_i,
    input  logic [NUM_CH*INT_W-1:0]  lim_i,
    output logic                     crit_n_o
);

    logic [NUM_CH-1:0] hot;

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        crit_temp_chan #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_chan (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .fmt_i  (fmt_i),
            .en_i   (en_i[k]),
            .vld_i  (vld_i[k]),
            .temp_i (temp_i[k*TEMP_W +: TEMP_W]),
            .lim_i  (lim_i[k*INT_W +: INT_W]),
            .hot_o  (hot[k])
        );
    end

    always_comb begin
        crit_n_o = ~(|hot);
    end

    // R9
    release_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(crit_n_o) |-> $past(|vld_i));

    // R2
    assert_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(crit_n_o) |-> $past(|vld_i));

endmodule

// File: tb/crit_temp_out_tb.sv
module crit_temp_out_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt = 1'b1;
    logic [2:0]  en = 3'b000;
    logic [2:0]  vld = 3'b000;
    logic [9:0]  t0 = '0, t1 = '0, t2 = '0;
    logic [7:0]  l0 = '0, l1 = '0, l2 = '0;
    logic [29:0] temp;
    logic [23:0] lim;
    logic        crit_n;
    int          n_chk = 0;
    int          n_err = 0;

    always #2 clk = ~clk;

    always_comb begin
        temp = {t2, t1, t0};
        lim  = {l2, l1, l0};
    end

    crit_temp_out u_dut (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .fmt_i    (fmt),
        .en_i     (en),
        .vld_i    (vld),
        .temp_i   (temp),
        .lim_i    (lim),
        .crit_n_o (crit_n)
    );

    task automatic chk(input string req, input logic exp);
        n_chk++;
        if (crit_n !== exp) begin
            n_err++;
            $display("FAIL %s crit_n actual=%0b expected=%0b", req, crit_n, exp);
        end
    endtask

    task automatic strobe(input logic [2:0] mask);
        @(negedge clk);
        vld = mask;
        @(negedge clk);
        vld = 3'b000;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R1 reset", 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 after reset", 1'b1);
    endtask

    task automatic t_trip_edge();
        fmt = 1'b1; en = 3'b111;
        l0 = 8'd80; l1 = 8'd80; l2 = 8'd80;
        t0 = 10'd320;                       // 80.00
        strobe(3'b001);
        chk("R3 equal no trip", 1'b1);
        t0 = 10'd321;                       // 80.25
        strobe(3'b001);
        chk("R2 R3 quarter above trips", 1'b0);
    endtask

    task automatic t_hold();
        t0 = 10'd200;
        repeat (5) @(negedge clk);
        chk("R4 held without strobe", 1'b0);
        t1 = 10'd100;
        strobe(3'b010);
        chk("R10 other strobe no effect", 1'b0);
        t0 = 10'd320;
        strobe(3'b001);
        chk("R5 release at limit", 1'b1);
    endtask

    task automatic t_or();
        t0 = 10'd400; t2 = 10'd400;
        strobe(3'b101);
        chk("R9 two tripped", 1'b0);
        t0 = 10'd100;
        strobe(3'b001);
        chk("R9 one still tripped", 1'b0);
        t2 = 10'd100;
        strobe(3'b100);
        chk("R9 all released", 1'b1);
    endtask

    task automatic t_neg();
        l0 = 8'hF6;                         // -10
        t0 = 10'd983;                       // -10.25
        strobe(3'b001);
        chk("R2 negative below", 1'b1);
        t0 = 10'd985;                       // -9.75
        strobe(3'b001);
        chk("R2 negative above", 1'b0);
        t0 = 10'd1000;                      // -6.00, release
        l0 = 8'd0;
        strobe(3'b001);
        chk("R5 release below", 1'b1);
    endtask

    task automatic t_enable();
        en = 3'b101;
        t1 = 10'd500;
        strobe(3'b010);
        chk("R6 disabled channel", 1'b1);
        en = 3'b111;
        t1 = 10'd100;
        strobe(3'b010);
    endtask

    task automatic t_offset();
        fmt = 1'b0;
        l0 = 8'd144;                        // 80 C
        t0 = {8'd144, 2'b00};
        strobe(3'b001);
        chk("R7 R3 offset equal", 1'b1);
        t0 = {8'd144, 2'b01};
        strobe(3'b001);
        chk("R7 R3 offset quarter above", 1'b0);
        t0 = {8'd100, 2'b00};
        strobe(3'b001);
        chk("R7 offset release", 1'b1);
        l0 = 8'd0; t0 = 10'h3FF;
        strobe(3'b001);
        chk("R7 limit -64 disables", 1'b1);
        l0 = 8'd1;
        strobe(3'b001);
        chk("R7 limit -63 armed", 1'b0);
        l0 = 8'd144; t0 = 10'd0;
        strobe(3'b001);
        chk("R7 offset release 2", 1'b1);
    endtask

    task automatic t_twos();
        fmt = 1'b1;
        l2 = 8'h80; t2 = 10'h1FF;           // limit -128, reading 127.75
        strobe(3'b100);
        chk("R8 limit -128 disables", 1'b1);
        l2 = 8'h81;
        strobe(3'b100);
        chk("R8 limit -127 armed", 1'b0);
        t2 = 10'h3FC;                       // -1.00 vs -127 still above
        strobe(3'b100);
        chk("R8 still above", 1'b0);
        l2 = 8'd0;
        strobe(3'b100);
        chk("R5 R8 release", 1'b1);
    endtask

    initial begin
        #(4 * 100000);
        n_err++;
        $display("FAIL R1 watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        t_reset();
        t_trip_edge();
        t_hold();
        t_or();
        t_neg();
        t_enable();
        t_offset();
        t_twos();
        repeat (2) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule